// File: doc/BRIEF.md
# Register-Write Sequence Bytecode Encoder

This block turns a stream of sequencer requests into a compact byte program kept in a local byte buffer. Four request kinds exist: a register write (address and data), a flag set, a wait on a flag, and a timed delay. For writes the encoder remembers the last address and the last data it put into the program. It leaves out a data load that would repeat the current data. It picks a two-byte or a four-byte operand depending on whether the upper half of the value changed.

Software or a controlling engine pulses `start`, then hands over requests with a valid/ready handshake, then pulses `finish`. The encoder writes one program byte per cycle. Once all bytes of the accepted requests are in the buffer, it reports how many 32-bit words the padded program takes and whether that count exceeds the configured word capacity. The program bytes can be read back through a byte read port. Every location past the end of the program reads as the pad value 0x7F.

Top module: `seq_bytecode_encoder`

## Requirements
- R1: A write whose data equals the tracked data emits no data load. If the upper 16 data bits differ from the tracked data, it emits 0xE2 followed by the four data bytes, least significant first. Otherwise it emits 0x42 followed by the low two data bytes, least significant first.
- R2: After any data load, a write emits its address command. If the upper 16 address bits differ from the tracked address, this is 0xE0 followed by four address bytes, least significant first. Otherwise it is 0x40 followed by the low two address bytes. The write then updates both tracked values.
- R3: Reset and `start` set the tracked address and data to all-ones and empty the program, so the first write uses both long forms. While `start` is high, `req_ready` is low and no request is taken.
- R4: A flag set emits one byte: 0x80 plus the flag index from `req_addr[4:0]`. Add 0x20 if `req_data`, read as signed, is at least 0, and add another 0x20 if it is at least 1.
- R5: A flag wait emits three bytes: 0x5F, then `req_addr[7:0]` (the flag index), then `req_data[7:0]` (the expected value).
- R6: A delay takes `req_data` in nanoseconds and divides by 1000 to get whole microseconds, clamped to 255. While any bit above bit 1 is set, it shifts right by two and counts the shift. It emits one byte: the count in bits [3:2] and the remaining value in bits [1:0].
- R7: Buffer locations at or past the byte count read as 0x7F. On completion, `word_count` equals (byte count + 4) / 4, using integer division.
- R8: On completion, `overflow` is 1 exactly when `word_count` exceeds `CAP_WORDS`.
- R9: A request is taken when `req_valid` and `req_ready` are both high. Its bytes are written one per cycle, and `req_ready` stays low until the last byte is written. A request taken in the same cycle as `finish` is part of the reported program. `done` is a one-cycle pulse.
- R10: Bytes past `BUF_BYTES` are dropped, and the byte count stops at `BUF_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new program: clears it and resets the tracked values |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder can take a request |
| req_kind | input | 2 | 0 write, 1 flag set, 2 flag wait, 3 delay |
| req_addr | input | 32 | Write address, or flag index |
| req_data | input | 32 | Write data, flag value, or delay in ns |
| finish | input | 1 | Closes the program once pending bytes are written |
| done | output | 1 | One-cycle pulse when the results are valid |
| word_count | output | $clog2(BUF_BYTES/4+2) | Padded program length in 32-bit words |
| overflow | output | 1 | Program exceeds CAP_WORDS |
| rd_idx | input | $clog2(BUF_BYTES) | Byte read index |
| rd_byte | output | 8 | Program byte, or 0x7F past the end |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a request handshake and `finish`: the bench raises both at the same clock edge. It then checks that the reported word count and the read-back bytes include that request's command, so completion waits for the last emitted byte. The second pair is `start` and a pending request: the bench raises both together and expects `req_ready` low in that cycle. It then expects an empty program of one word, with byte 0 reading 0x7F. A later write must come out in long forms.

// File: rtl/seqenc_pkg.sv
package seqenc_pkg;
   typedef enum logic [1:0] {
      K_WRITE = 2'd0,
      K_SETF  = 2'd1,
      K_WAIT  = 2'd2,
      K_DELAY = 2'd3
   } req_kind_e;

   // longest command group: data load + address load, both long
   localparam int MAX_CMD = 10;

   localparam logic [7:0] OP_DATA_LONG  = 8'hE2;
   localparam logic [7:0] OP_DATA_SHORT = 8'h42;
   localparam logic [7:0] OP_ADDR_LONG  = 8'hE0;
   localparam logic [7:0] OP_ADDR_SHORT = 8'h40;
   localparam logic [7:0] OP_WAIT       = 8'h5F;
   localparam logic [7:0] OP_FLAG       = 8'h80;
   localparam logic [7:0] PAD_BYTE      = 8'h7F;

   typedef logic [MAX_CMD-1:0][7:0] cmd_bytes_t;
endpackage

// File: rtl/seqenc_delay.sv
module seqenc_delay #(
   parameter int SATURATE = 1
) (
   input  logic [31:0] nsec,
   output logic [7:0]  code
);
   logic [31:0] us_full;
   logic [7:0]  us8;
   logic [7:0]  mant;
   logic [1:0]  shift;

   assign us_full = nsec / 32'd1000;

   generate
      if (SATURATE != 0) begin : g_clamp
         assign us8 = (us_full > 32'd255) ? 8'hFF : us_full[7:0];
      end else begin : g_wrap
         assign us8 = us_full[7:0];
      end
   endgenerate

   always_comb begin
      mant  = us8;
      shift = 2'd0;
      for (int i = 0; i < 3; i++) begin
         if (mant[7:2] != 6'd0) begin
            mant  = mant >> 2;
            shift = shift + 2'd1;
         end
      end
      code = {4'b0000, shift, mant[1:0]};
   end
endmodule

// File: rtl/seqenc_format.sv
module seqenc_format
   import seqenc_pkg::*;
(
   input  req_kind_e   kind,
   input  logic [31:0] addr,
   input  logic [31:0] data,
   input  logic [31:0] last_addr,
   input  logic [31:0] last_data,
   input  logic [7:0]  delay_code,
   output cmd_bytes_t  bytes,
   output logic [3:0]  len
);
   logic [3:0] p;
   logic [7:0] flag_b;

   always_comb begin
      flag_b = OP_FLAG + {3'b000, addr[4:0]};
      if ($signed(data) >= 0) flag_b = flag_b + 8'h20;
      if ($signed(data) >= 1) flag_b = flag_b + 8'h20;
   end

   always_comb begin
      bytes = {MAX_CMD{PAD_BYTE}};
      p     = 4'd0;
      case (kind)
         K_WRITE: begin
            if (data != last_data) begin
               if (data[31:16] != last_data[31:16]) begin
                  bytes[p]       = OP_DATA_LONG;
                  bytes[p+4'd1]  = data[7:0];
                  bytes[p+4'd2]  = data[15:8];
                  bytes[p+4'd3]  = data[23:16];
                  bytes[p+4'd4]  = data[31:24];
                  p              = p + 4'd5;
               end else begin
                  bytes[p]       = OP_DATA_SHORT;
                  bytes[p+4'd1]  = data[7:0];
                  bytes[p+4'd2]  = data[15:8];
                  p              = p + 4'd3;
               end
            end
            if (addr[31:16] != last_addr[31:16]) begin
               bytes[p]       = OP_ADDR_LONG;
               bytes[p+4'd1]  = addr[7:0];
               bytes[p+4'd2]  = addr[15:8];
               bytes[p+4'd3]  = addr[23:16];
               bytes[p+4'd4]  = addr[31:24];
               p              = p + 4'd5;
            end else begin
               bytes[p]       = OP_ADDR_SHORT;
               bytes[p+4'd1]  = addr[7:0];
               bytes[p+4'd2]  = addr[15:8];
               p              = p + 4'd3;
            end
         end
         K_SETF: begin
            bytes[0] = flag_b;
            p        = 4'd1;
         end
         K_WAIT: begin
            bytes[0] = OP_WAIT;
            bytes[1] = addr[7:0];
            bytes[2] = data[7:0];
            p        = 4'd3;
         end
         default: begin
            bytes[0] = delay_code;
            p        = 4'd1;
         end
      endcase
      len = p;
   end
endmodule

// File: rtl/seqenc_store.sv
module seqenc_store
   import seqenc_pkg::*;
#(
   parameter int BUF_BYTES = 512,
   localparam int IDX_W = $clog2(BUF_BYTES),
   localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             wr_en,
   input  logic [7:0]       wr_byte,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_byte,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_BYTES);

   logic [7:0] mem [BUF_BYTES];
   logic       room;

   assign room = (count < FULL);

   always_ff @(posedge clk) begin
      if (wr_en && room && !clear) mem[count[IDX_W-1:0]] <= wr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (clear)          count <= '0;
      else if (wr_en && room)  count <= count + CNT_W'(1);
   end

   assign rd_byte = ({1'b0, rd_idx} < count) ? mem[rd_idx] : PAD_BYTE;
endmodule

// File: rtl/seq_bytecode_encoder.sv
module seq_bytecode_encoder
   import seqenc_pkg::*;
#(
   parameter int BUF_BYTES = 512,
   parameter int CAP_WORDS = 128,
   parameter int SAT_DELAY = 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               start,
   input  logic                               req_valid,
   output logic                               req_ready,
   input  logic [1:0]                         req_kind,
   input  logic [31:0]                        req_addr,
   input  logic [31:0]                        req_data,
   input  logic                               finish,
   output logic                               done,
   output logic [$clog2(BUF_BYTES/4+2)-1:0]   word_count,
   output logic                               overflow,
   input  logic [$clog2(BUF_BYTES)-1:0]       rd_idx,
   output logic [7:0]                         rd_byte
);
   localparam int CNT_W = $clog2(BUF_BYTES + 1);
   localparam int WC_W  = $clog2(BUF_BYTES/4 + 2);

   generate
      if ((BUF_BYTES < 16) || ((BUF_BYTES & (BUF_BYTES - 1)) != 0)) begin : g_bad_buf
         $error("BUF_BYTES must be a power of two of at least 16");
      end
      if ((CAP_WORDS < 1) || (CAP_WORDS * 4 > BUF_BYTES)) begin : g_bad_cap
         $error("CAP_WORDS must fit inside BUF_BYTES");
      end
   endgenerate

   req_kind_e        kind;
   cmd_bytes_t       f_bytes, em_bytes;
   logic [3:0]       f_len, em_len, em_idx;
   logic [7:0]       dly_code;
   logic [31:0]      last_addr, last_data;
   logic             busy, fin_pend, accept;
   logic [CNT_W-1:0] byte_cnt, padded;
   logic [WC_W-1:0]  words;

   assign kind      = req_kind_e'(req_kind);
   assign req_ready = !busy && !fin_pend && !start;
   assign accept    = req_valid && req_ready;
   assign padded    = byte_cnt + CNT_W'(4);
   assign words     = WC_W'(padded >> 2);

   seqenc_delay #(.SATURATE(SAT_DELAY)) u_delay (
      .nsec (req_data),
      .code (dly_code)
   );

   seqenc_format u_format (
      .kind       (kind),
      .addr       (req_addr),
      .data       (req_data),
      .last_addr  (last_addr),
      .last_data  (last_data),
      .delay_code (dly_code),
      .bytes      (f_bytes),
      .len        (f_len)
   );

   seqenc_store #(.BUF_BYTES(BUF_BYTES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .wr_en   (busy),
      .wr_byte (em_bytes[em_idx]),
      .rd_idx  (rd_idx),
      .rd_byte (rd_byte),
      .count   (byte_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         em_bytes   <= '0;
         em_len     <= '0;
         em_idx     <= '0;
         last_addr  <= '1;
         last_data  <= '1;
         fin_pend   <= 1'b0;
         done       <= 1'b0;
         word_count <= '0;
         overflow   <= 1'b0;
      end else if (start) begin
         busy       <= 1'b0;
         em_idx     <= '0;
         last_addr  <= '1;
         last_data  <= '1;
         fin_pend   <= 1'b0;
         done       <= 1'b0;
         word_count <= '0;
         overflow   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            em_bytes <= f_bytes;
            em_len   <= f_len;
            em_idx   <= '0;
            busy     <= 1'b1;
            if (kind == K_WRITE) begin
               last_addr <= req_addr;
               last_data <= req_data;
            end
         end else if (busy) begin
            em_idx <= em_idx + 4'd1;
            if (em_idx == em_len - 4'd1) busy <= 1'b0;
         end
         if (fin_pend && !busy) begin
            fin_pend   <= 1'b0;
            done       <= 1'b1;
            word_count <= words;
            overflow   <= (words > WC_W'(CAP_WORDS));
         end else if (finish) begin
            fin_pend <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/seqenc_chk.sv
module seqenc_chk #(
   parameter int BUF_BYTES = 512,
   parameter int CAP_WORDS = 128,
   localparam int CNT_W = $clog2(BUF_BYTES + 1),
   localparam int WC_W  = $clog2(BUF_BYTES/4 + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             req_valid,
   input logic             req_ready,
   input logic             done,
   input logic             overflow,
   input logic [WC_W-1:0]  word_count,
   input logic [CNT_W-1:0] byte_cnt,
   input logic             busy,
   input logic [31:0]      last_addr,
   input logic [31:0]      last_data
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_BYTES);

   p_accept_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !start) |=> !req_ready);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_byte_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (byte_cnt == $past(byte_cnt) + CNT_W'(1)) || (byte_cnt == FULL));

   p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (byte_cnt == '0) && (last_addr == '1) && (last_data == '1));

   p_start_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !req_ready);

   p_pad_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (word_count != '0));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (overflow == (word_count > WC_W'(CAP_WORDS))));

   p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= FULL);
endmodule

bind seq_bytecode_encoder seqenc_chk #(
   .BUF_BYTES (BUF_BYTES),
   .CAP_WORDS (CAP_WORDS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .done       (done),
   .overflow   (overflow),
   .word_count (word_count),
   .byte_cnt   (byte_cnt),
   .busy       (busy),
   .last_addr  (last_addr),
   .last_data  (last_data)
);

// File: tb/seq_bytecode_encoder_test.sv
module seq_bytecode_encoder_test;
   localparam int BUFB = 512;
   localparam int CAPW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = 2'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_data = '0;
   logic        finish = 1'b0;
   logic        done;
   logic [7:0]  word_count;
   logic        overflow;
   logic [8:0]  rd_idx = '0;
   logic [7:0]  rd_byte;

   int errors = 0;
   int checks = 0;
   bit reported = 1'b0;

   logic [7:0]  m_mem [BUFB];
   int          m_cnt;
   logic [31:0] m_la, m_ld;

   always #4 clk = ~clk;

   seq_bytecode_encoder #(.BUF_BYTES(BUFB), .CAP_WORDS(CAPW), .SAT_DELAY(1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
      .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
      .req_data(req_data), .finish(finish), .done(done),
      .word_count(word_count), .overflow(overflow), .rd_idx(rd_idx),
      .rd_byte(rd_byte)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
      end
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      summary();
   end

   // ---------------- model, built from the requirements ----------------
   task automatic m_clear();
      m_cnt = 0;
      m_la  = '1;
      m_ld  = '1;
   endtask

   task automatic m_push(input logic [7:0] b);
      if (m_cnt < BUFB) begin
         m_mem[m_cnt] = b;
         m_cnt++;
      end
   endtask

   function automatic logic [7:0] dly_byte(input logic [31:0] ns);
      int unsigned us = ns / 1000;
      int unsigned sh = 0;
      if (us > 255) us = 255;
      while ((us & ~32'd3) != 0) begin
         us = us >> 2;
         sh++;
      end
      return 8'((sh << 2) | us);
   endfunction

   task automatic m_enc(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
      logic [7:0] b;
      case (k)
         2'd0: begin
            if (d != m_ld) begin
               if (d[31:16] != m_ld[31:16]) begin
                  m_push(8'hE2); m_push(d[7:0]); m_push(d[15:8]);
                  m_push(d[23:16]); m_push(d[31:24]);
               end else begin
                  m_push(8'h42); m_push(d[7:0]); m_push(d[15:8]);
               end
            end
            if (a[31:16] != m_la[31:16]) begin
               m_push(8'hE0); m_push(a[7:0]); m_push(a[15:8]);
               m_push(a[23:16]); m_push(a[31:24]);
            end else begin
               m_push(8'h40); m_push(a[7:0]); m_push(a[15:8]);
            end
            m_la = a;
            m_ld = d;
         end
         2'd1: begin
            b = 8'h80 + {3'b000, a[4:0]};
            if ($signed(d) >= 0) b = b + 8'h20;
            if ($signed(d) >= 1) b = b + 8'h20;
            m_push(b);
         end
         2'd2: begin
            m_push(8'h5F); m_push(a[7:0]); m_push(d[7:0]);
         end
         default: m_push(dly_byte(d));
      endcase
   endtask

   // ---------------- drivers ----------------
   task automatic issue(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d,
                        input bit with_finish = 1'b0);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_kind  = k;
      req_addr  = a;
      req_data  = d;
      req_valid = 1'b1;
      finish    = with_finish;
      m_enc(k, a, d);
      @(negedge clk);
      req_valid = 1'b0;
      finish    = 1'b0;
   endtask

   task automatic do_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      m_clear();
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      check("R9 done pulse seen", {31'd0, done}, 32'd1);
   endtask

   task automatic close_prog();
      @(negedge clk);
      finish = 1'b1;
      @(negedge clk);
      finish = 1'b0;
      wait_done();
   endtask

   task automatic read_byte(input int i, output logic [7:0] b);
      rd_idx = 9'(i);
      #1;
      b = rd_byte;
   endtask

   task automatic verify(input string tag);
      int unsigned wexp = (m_cnt + 4) / 4;
      int last = m_cnt + 3;
      logic [7:0] b;
      check({tag, " R7 word_count"}, {24'd0, word_count}, wexp);
      check({tag, " R8 overflow"}, {31'd0, overflow}, {31'd0, (wexp > CAPW)});
      @(negedge clk);
      check({tag, " R9 done cleared"}, {31'd0, done}, 32'd0);
      if (last > BUFB - 1) last = BUFB - 1;
      for (int i = 0; i <= last; i++) begin
         read_byte(i, b);
         check($sformatf("%s R1/R2/R7 byte %0d", tag, i), {24'd0, b},
               {24'd0, (i < m_cnt) ? m_mem[i] : 8'h7F});
      end
   endtask

   function automatic logic [31:0] pick_val(input logic [31:0] prev);
      case ($urandom_range(3))
         0:       return prev;
         1:       return {prev[31:16], 16'($urandom)};
         default: return $urandom;
      endcase
   endfunction

   // ---------------- scenario ----------------
   initial begin
      logic [7:0] b;
      void'($urandom(32'd7717));
      m_clear();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset ready", {31'd0, req_ready}, 32'd1);
      check("R9 reset done low", {31'd0, done}, 32'd0);
      read_byte(0, b);
      check("R7 reset pad byte", {24'd0, b}, 32'h7F);

      // directed program, straight after reset
      issue(2'd0, 32'h0012_3456, 32'hCAFE_BABE);   // R3 first write long forms
      issue(2'd0, 32'h0012_0010, 32'hCAFE_BABE);   // R1 skip data, R2 short address
      issue(2'd0, 32'h0012_0020, 32'hCAFE_0001);   // R1 short data
      issue(2'd1, 32'd3, 32'hFFFF_FFFF);           // R4 value -1
      issue(2'd1, 32'd3, 32'd0);                   // R4 value 0
      issue(2'd1, 32'd31, 32'd1);                  // R4 value 1
      issue(2'd2, 32'd5, 32'd1);                   // R5
      issue(2'd3, 32'd0, 32'd100000);              // R6 three shifts
      issue(2'd3, 32'd0, 32'd999);                 // R6 rounds to zero
      issue(2'd3, 32'd0, 32'd1000000);             // R6 clamp
      issue(2'd3, 32'd0, 32'd5000);                // R6 one shift
      close_prog();
      check("R7 directed word_count", {24'd0, word_count}, 32'd8);
      read_byte(0, b);  check("R1 long data opcode", {24'd0, b}, 32'hE2);
      read_byte(5, b);  check("R2 long addr opcode", {24'd0, b}, 32'hE0);
      read_byte(10, b); check("R1 R2 skip then short addr", {24'd0, b}, 32'h40);
      read_byte(13, b); check("R1 short data opcode", {24'd0, b}, 32'h42);
      read_byte(19, b); check("R4 flag -1", {24'd0, b}, 32'h83);
      read_byte(21, b); check("R4 flag +1 idx31", {24'd0, b}, 32'hDF);
      read_byte(22, b); check("R5 wait opcode", {24'd0, b}, 32'h5F);
      read_byte(25, b); check("R6 delay 100us", {24'd0, b}, 32'h0D);
      read_byte(27, b); check("R6 delay clamp", {24'd0, b}, 32'h0F);
      read_byte(28, b); check("R6 delay 5us", {24'd0, b}, 32'h05);
      verify("directed");

      // start together with a request: start wins
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      start = 1'b1; req_valid = 1'b1; req_kind = 2'd1; req_addr = 32'd2; req_data = 32'd0;
      #1 check("R3 ready low during start", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      start = 1'b0; req_valid = 1'b0;
      m_clear();
      close_prog();
      check("R3 empty program words", {24'd0, word_count}, 32'd1);
      verify("after start");
      issue(2'd0, 32'h0012_0010, 32'hCAFE_BABE);   // R3 long forms again
      close_prog();
      read_byte(0, b); check("R3 long after start", {24'd0, b}, 32'hE2);
      verify("R3 relong");

      // request taken in the same cycle as finish
      do_start();
      issue(2'd2, 32'd9, 32'd0);
      issue(2'd0, 32'hAB00_0004, 32'h1234_5678, 1'b1);
      wait_done();
      check("R9 same-cycle finish words", {24'd0, word_count}, 32'd4);
      verify("R9 same-cycle");

      // capacity boundary: 63 bytes fit in 16 words, 64 bytes do not
      do_start();
      for (int i = 0; i < 63; i++) issue(2'd1, 32'(i % 32), 32'd1);
      close_prog();
      check("R8 63 bytes no overflow", {31'd0, overflow}, 32'd0);
      verify("R8 fit");
      issue(2'd1, 32'd0, 32'd0);
      close_prog();
      check("R8 64 bytes overflow", {31'd0, overflow}, 32'd1);
      verify("R8 over");

      // buffer saturation
      do_start();
      for (int i = 0; i < 52; i++) issue(2'd0, {16'(i + 1), 16'h0100}, {16'(i + 7), 16'h0002});
      close_prog();
      check("R10 saturated words", {24'd0, word_count}, 32'd129);
      verify("R10 sat");

      // constrained random programs
      for (int p = 0; p < 8; p++) begin
         int nreq = 3 + $urandom_range(9);
         do_start();
         for (int r = 0; r < nreq; r++) begin
            int k = $urandom_range(3);
            case (k)
               0: issue(2'd0, pick_val(m_la), pick_val(m_ld));
               1: issue(2'd1, 32'($urandom_range(31)), 32'($signed($urandom_range(3)) - 1));
               2: issue(2'd2, 32'($urandom_range(255)), 32'($urandom_range(255)));
               default: issue(2'd3, 32'd0, 32'($urandom_range(2000000)));
            endcase
         end
         close_prog();
         verify($sformatf("random %0d", p));
      end

      summary();
   end
endmodule